// File: doc/BRIEF.md
# Pipelined Radix-4 Signed/Unsigned Multiplier

This block multiplies two 16-bit operands and returns the 32-bit product three clock cycles after the operands are presented. A per-operand mode bit selects whether the pair is read as two's-complement signed or as unsigned numbers, so signed and unsigned products can be interleaved freely. The block accepts one new operand pair on every clock, and pairs may be separated by any number of idle cycles.

Internally the multiplier operand is recoded into radix-4 digits, each taking a value from -2 to +2. Every digit selects a shifted multiple of the other operand, giving nine partial-product rows and one constant/correction row. A tree of 4:2 compressors reduces these rows to two, and a carry-select adder adds the last two. Registers after the partial products, after half of the tree, and after the final adder form three stages. Each stage loads its data register only when the stage before it holds a valid entry, so idle stages do not toggle.

The data stream is valid-only. There is no ready signal and no back-pressure. The consumer must take a result in the single cycle that `out_valid` is high. A new pair is accepted whenever `in_valid` is high, including on every clock.

Top module: `mulb_booth_wallace_mul`

## Requirements
- R1: With `in_sgn` = 0, `out_p` equals the unsigned product of `in_a` and `in_b` (both read as 0..65535).
- R2: With `in_sgn` = 1, `out_p` equals the 32-bit two's-complement product of `in_a` and `in_b` (both read as -32768..32767).
- R3: The multiplier operand is recoded into 9 radix-4 digits in {-2,-1,0,+1,+2} whose weighted sum (digit i weighted by 4^i) equals the multiplier value under the selected mode.
- R4: The compressor tree preserves the modulo-2^32 sum of its rows while reducing ten rows to two.
- R5: The final carry-select adder returns the modulo-2^32 sum of the two remaining rows.
- R6: `out_valid` is high in exactly the cycle three clocks after the edge that sampled `in_valid` high, and low otherwise. Back-to-back inputs give back-to-back outputs.
- R7: Operands and mode presented while `in_valid` is low are ignored. `out_p` keeps the last product while no new result is delivered, and idle gaps do not alter later results.
- R8: An operand of zero gives a product of zero in either mode. This includes 0 times the largest value and the largest value times 0.
- R9: The synchronous active-high `rst` clears every valid bit. `out_valid` is low during reset and afterwards until a pair accepted after reset has passed through the pipeline. Pairs in flight when reset is applied produce no output.
- R10: The mode bit is sampled together with its operands, so consecutive pairs with different modes each use their own mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair present this cycle |
| in_sgn | input | 1 | 1: signed operands, 0: unsigned |
| in_a | input | 16 | Multiplicand |
| in_b | input | 16 | Multiplier (recoded operand) |
| out_valid | output | 1 | Product present this cycle |
| out_p | output | 32 | Product |

## Verification
The corner pairs (zero against the largest value in each mode, the most negative value squared, and all-ones read both ways) separate errors in the sign extension of the operands from errors in the row-sign correction constant. Pairs that straddle the sign boundary (+1/-1, 0x7FFF/0x8001) and walking-one operands expose a wrong digit decode or a wrong shift of a single row. Alternating the mode on the same operands, back to back, shows whether the mode travels with its data. Random pairs with random idle gaps and garbage on the idle inputs check the clock-enabled stages, and a reset applied with pairs in flight checks that those pairs are dropped.

// File: rtl/mulb_pkg.sv
package mulb_pkg;

  // One radix-4 digit: magnitude one or two, and its sign.
  typedef struct packed {
    logic neg;
    logic two;
    logic one;
  } bdig_t;

  // Rows left after one reduction level: groups of four become two,
  // a lone group of three goes through one full-adder row.
  function automatic int unsigned rows_next(int unsigned n);
    if (n <= 2) return n;
    if (n == 3) return 2;
    return (n / 4) * 2 + (n % 4);
  endfunction

  function automatic int unsigned rows_at(int unsigned n0, int unsigned lvl);
    int unsigned n;
    n = n0;
    for (int k = 0; k < int'(lvl); k++) n = rows_next(n);
    return n;
  endfunction

  function automatic int unsigned level_count(int unsigned n0);
    int unsigned n;
    int unsigned c;
    n = n0;
    c = 0;
    while (n > 2) begin
      n = rows_next(n);
      c++;
    end
    return c;
  endfunction

  function automatic int digit_val(bdig_t d);
    int v;
    v = d.two ? 2 : (d.one ? 1 : 0);
    return d.neg ? -v : v;
  endfunction

endpackage

// File: rtl/mulb_booth_rows.sv
module mulb_booth_rows
  import mulb_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0]                     a_i,
  input  logic [WIDTH-1:0]                     b_i,
  input  logic                                 sgn_i,
  output logic [WIDTH/2+1:0][2*WIDTH-1:0]      rows_o,
  output bdig_t [WIDTH/2:0]                    digs_o
);
  localparam int XW    = WIDTH + 1;     // extended operand width
  localparam int MW    = WIDTH + 2;     // width of a selected multiple
  localparam int PW    = 2 * WIDTH;     // product width
  localparam int NDIG  = WIDTH / 2 + 1; // radix-4 digits

  // Each row is written as {~sign, low bits}, worth (row - 2^(MW-1)).
  // The sum of those offsets is folded into one constant. Its low MW-1
  // bits are zero, so the negation bits (at positions <= WIDTH) can be ORed in.
  function automatic logic [PW-1:0] ext_const();
    logic [PW-1:0] c;
    c = '0;
    for (int i = 0; i < NDIG; i++)
      if (MW - 1 + 2 * i < PW) c = c - (PW'(1) << (MW - 1 + 2 * i));
    return c;
  endfunction
  localparam logic [PW-1:0] EXT_CONST = ext_const();

  logic [XW-1:0]   a_x;
  logic            b_ext;
  logic [XW+1:0]   b_w;   // index j holds multiplier bit j-1 (bit -1 is 0)
  logic [NDIG-1:0] neg_v;
  logic [PW-1:0]   neg_row;

  assign a_x   = {sgn_i & a_i[WIDTH-1], a_i};
  assign b_ext = sgn_i & b_i[WIDTH-1];
  assign b_w   = {b_ext, b_ext, b_i, 1'b0};

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    logic [2:0]    trip;
    bdig_t         d;
    logic [MW-1:0] mag;
    logic [MW-1:0] sel;

    assign trip  = b_w[2*i+2 -: 3];
    assign d.one = trip[1] ^ trip[0];
    assign d.two = (trip == 3'b100) | (trip == 3'b011);
    assign d.neg = trip[2] & ~(trip[1] & trip[0]);

    assign mag = d.two ? {a_x, 1'b0}
               : (d.one ? {a_x[XW-1], a_x} : '0);
    // Negative digit: ones' complement here, the +1 rides in neg_row.
    assign sel = mag ^ {MW{d.neg}};

    assign rows_o[i] = PW'({~sel[MW-1], sel[MW-2:0]}) << (2 * i);
    assign digs_o[i] = d;
    assign neg_v[i]  = d.neg;
  end

  always_comb begin
    neg_row = '0;
    for (int i = 0; i < NDIG; i++) neg_row[2*i] = neg_v[i];
  end

  assign rows_o[NDIG] = EXT_CONST | neg_row;

endmodule

// File: rtl/mulb_csa_level.sv
module mulb_csa_level
  import mulb_pkg::*;
#(
  parameter int W   = 32,
  parameter int NIN = 10
) (
  input  logic [NIN-1:0][W-1:0]                 rows_i,
  output logic [int'(rows_next(NIN))-1:0][W-1:0] rows_o
);
  localparam int NGRP = NIN / 4;
  localparam int NREM = NIN % 4;

  if (NIN == 3) begin : g_fa
    logic [W-1:0] x, y, z;
    assign x = rows_i[0];
    assign y = rows_i[1];
    assign z = rows_i[2];
    assign rows_o[0] = x ^ y ^ z;
    assign rows_o[1] = {(x[W-2:0] & y[W-2:0]) | (x[W-2:0] & z[W-2:0])
                        | (y[W-2:0] & z[W-2:0]), 1'b0};
  end else begin : g_c42
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
      logic [W-1:0] a, b, c, d, s1, ci, c2;
      assign a = rows_i[4*g];
      assign b = rows_i[4*g+1];
      assign c = rows_i[4*g+2];
      assign d = rows_i[4*g+3];
      // first full adder; its carry moves one column left, no ripple
      assign s1 = a ^ b ^ c;
      assign ci = {(a[W-2:0] & b[W-2:0]) | (a[W-2:0] & c[W-2:0])
                   | (b[W-2:0] & c[W-2:0]), 1'b0};
      // second full adder merges the fourth row and the lateral carry
      assign rows_o[2*g] = s1 ^ d ^ ci;
      assign c2 = {(s1[W-2:0] & d[W-2:0]) | (s1[W-2:0] & ci[W-2:0])
                   | (d[W-2:0] & ci[W-2:0]), 1'b0};
      assign rows_o[2*g+1] = c2;
    end
    for (genvar j = 0; j < NREM; j++) begin : g_pass
      assign rows_o[2*NGRP+j] = rows_i[4*NGRP+j];
    end
  end

endmodule

// File: rtl/mulb_csel_add.sv
module mulb_csel_add #(
  parameter int W   = 32,
  parameter int BLK = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  localparam int NBLK = W / BLK;

  logic [NBLK-1:0] cy;   // carry into each block
  assign cy[0] = 1'b0;

  for (genvar j = 0; j < NBLK; j++) begin : g_blk
    logic [BLK-1:0] aj, bj;
    assign aj = a_i[j*BLK +: BLK];
    assign bj = b_i[j*BLK +: BLK];
    if (j == NBLK - 1) begin : g_last
      logic [BLK-1:0] t0, t1;
      assign t0 = aj + bj;
      assign t1 = aj + bj + BLK'(1);
      assign sum_o[j*BLK +: BLK] = cy[j] ? t1 : t0;
    end else begin : g_mid
      logic [BLK:0] t0, t1;
      assign t0 = {1'b0, aj} + {1'b0, bj};
      assign t1 = {1'b0, aj} + {1'b0, bj} + (BLK+1)'(1);
      assign sum_o[j*BLK +: BLK] = cy[j] ? t1[BLK-1:0] : t0[BLK-1:0];
      assign cy[j+1] = cy[j] ? t1[BLK] : t0[BLK];
    end
  end

endmodule

// File: rtl/mulb_booth_wallace_mul.sv
module mulb_booth_wallace_mul
  import mulb_pkg::*;
#(
  parameter int WIDTH    = 16,
  parameter int CSEL_BLK = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 in_sgn,
  input  logic [WIDTH-1:0]     in_a,
  input  logic [WIDTH-1:0]     in_b,
  output logic                 out_valid,
  output logic [2*WIDTH-1:0]   out_p
);
  localparam int PW    = 2 * WIDTH;
  localparam int NDIG  = WIDTH / 2 + 1;
  localparam int NROWS = NDIG + 1;
  localparam int NLEV  = int'(level_count(NROWS));
  localparam int SPLIT = (NLEV + 1) / 2;
  localparam int MIDR  = int'(rows_at(NROWS, SPLIT));

  // ---------------- stage 1: recoding and partial products -------------
  logic [NROWS-1:0][PW-1:0] pp_rows, r1_q;
  bdig_t [NDIG-1:0]         digs;
  logic                     v1_q, v2_q, v3_q;

  mulb_booth_rows #(.WIDTH(WIDTH)) u_rows (
    .a_i(in_a), .b_i(in_b), .sgn_i(in_sgn), .rows_o(pp_rows), .digs_o(digs)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      v3_q <= 1'b0;
    end else begin
      v1_q <= in_valid;
      v2_q <= v1_q;
      v3_q <= v2_q;
    end
  end

  always_ff @(posedge clk) if (in_valid) r1_q <= pp_rows;

  // ---------------- stages 2 and 3: compressor tree --------------------
  logic [MIDR-1:0][PW-1:0] mid_rows, r2_q;
  logic [PW-1:0]           fin0, fin1, add_sum, p_q;

  for (genvar k = 0; k < NLEV; k++) begin : g_lv
    localparam int NI = int'(rows_at(NROWS, k));
    localparam int NO = int'(rows_next(NI));
    logic [NI-1:0][PW-1:0] din;
    logic [NO-1:0][PW-1:0] dout;
    if (k == 0) begin : g_src_s1
      assign din = r1_q;
    end else if (k == SPLIT) begin : g_src_s2
      assign din = r2_q;
    end else begin : g_src_prev
      assign din = g_lv[k-1].dout;
    end
    mulb_csa_level #(.W(PW), .NIN(NI)) u_lvl (.rows_i(din), .rows_o(dout));
  end

  assign mid_rows = g_lv[SPLIT-1].dout;

  always_ff @(posedge clk) if (v1_q) r2_q <= mid_rows;

  if (SPLIT == NLEV) begin : g_fin_reg
    assign fin0 = r2_q[0];
    assign fin1 = r2_q[1];
  end else begin : g_fin_tree
    assign fin0 = g_lv[NLEV-1].dout[0];
    assign fin1 = g_lv[NLEV-1].dout[1];
  end

  mulb_csel_add #(.W(PW), .BLK(CSEL_BLK)) u_add (
    .a_i(fin0), .b_i(fin1), .sum_o(add_sum)
  );

  always_ff @(posedge clk) if (v2_q) p_q <= add_sum;

  assign out_valid = v3_q;
  assign out_p     = p_q;

  // ---------------- assertions ----------------------------------------
  int            recon;
  int            b_val;
  logic [PW-1:0] s_r1, s_mid, s_r2;

  always_comb begin
    recon = 0;
    for (int i = 0; i < NDIG; i++) recon += digit_val(digs[i]) * (1 << (2 * i));
    b_val = in_sgn ? int'($signed(in_b)) : int'(in_b);
    s_r1 = '0;
    for (int i = 0; i < NROWS; i++) s_r1 += r1_q[i];
    s_mid = '0;
    for (int i = 0; i < MIDR; i++) s_mid += mid_rows[i];
    s_r2 = '0;
    for (int i = 0; i < MIDR; i++) s_r2 += r2_q[i];
  end

  a_r3_recode_value: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (recon == b_val));

  a_r4_upper_tree_sum: assert property (@(posedge clk) disable iff (rst)
    v1_q |-> (s_mid == s_r1));

  a_r4_lower_tree_sum: assert property (@(posedge clk) disable iff (rst)
    v2_q |-> ((fin0 + fin1) == s_r2));

  a_r5_final_add: assert property (@(posedge clk) disable iff (rst)
    v2_q |-> (add_sum == PW'(fin0 + fin1)));

  a_r6_valid_after_three: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##3 out_valid);

  a_r6_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##3 !out_valid);

  a_r8_zero_operand: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_a == '0 || in_b == '0)) |-> ##3 (out_p == '0));

  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> !out_valid);

endmodule

// File: tb/mulb_booth_wallace_mul_tb_top.sv
module mulb_booth_wallace_mul_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_sgn = 1'b0;
  logic [15:0] in_a = '0;
  logic [15:0] in_b = '0;
  logic        out_valid;
  logic [31:0] out_p;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  logic [31:0] last_p = '0;

  typedef struct {
    int          due;
    logic [31:0] p;
    string       req;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;   // 125 MHz
  always @(posedge clk) cyc++;

  mulb_booth_wallace_mul dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sgn(in_sgn),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_p(out_p)
  );

  function automatic void chk(input bit ok, input string req,
                              input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endfunction

  function automatic logic [31:0] model(input logic s, input logic [15:0] a,
                                        input logic [15:0] b);
    logic signed [31:0] sa, sb;
    if (s) begin
      sa = {{16{a[15]}}, a};
      sb = {{16{b[15]}}, b};
      return sa * sb;
    end
    return {16'b0, a} * {16'b0, b};
  endfunction

  // Output monitor: every cycle either a scheduled product or no valid (R6).
  always @(negedge clk) begin
    if (!rst) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        chk(out_valid === 1'b1, {q[0].req, "/R6 valid"}, {31'b0, out_valid}, 32'd1);
        chk(out_p === q[0].p, q[0].req, out_p, q[0].p);
        last_p = q[0].p;
        void'(q.pop_front());
      end else begin
        chk(out_valid === 1'b0, "R6 idle", {31'b0, out_valid}, 32'd0);
      end
    end
  end

  task automatic push(input logic s, input logic [15:0] a, input logic [15:0] b,
                      input string req);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1;
    in_sgn   = s;
    in_a     = a;
    in_b     = b;
    e.due = cyc + 3;
    e.p   = model(s, a, b);
    e.req = req;
    q.push_back(e);
  endtask

  // Idle cycles carry garbage operands that must be ignored (R7).
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_sgn   = 1'($urandom);
      in_a     = 16'($urandom);
      in_b     = 16'($urandom);
    end
  endtask

  task automatic drain();
    idle(1);
    while (q.size() > 0) idle(1);
    idle(1);
  endtask

  task automatic t_reset_state();   // R9
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(out_valid === 1'b0, "R9 during reset", {31'b0, out_valid}, 32'd0);
    end
    rst = 1'b0;
    idle(3);   // monitor checks out_valid stays low
  endtask

  task automatic t_corners();       // R8, R1, R2
    push(1'b1, 16'h0000, 16'h7FFF, "R8 0 x max signed");
    push(1'b1, 16'h7FFF, 16'h0000, "R8 max x 0 signed");
    push(1'b0, 16'h0000, 16'hFFFF, "R8 0 x max unsigned");
    push(1'b0, 16'hFFFF, 16'h0000, "R8 max x 0 unsigned");
    push(1'b1, 16'h0000, 16'h8000, "R8 0 x min signed");
    push(1'b0, 16'hFFFF, 16'hFFFF, "R1 max x max unsigned");
    push(1'b1, 16'h8000, 16'h8000, "R2 min x min signed");
    push(1'b1, 16'h7FFF, 16'h7FFF, "R2 max x max signed");
    push(1'b1, 16'h8000, 16'h7FFF, "R2 min x max signed");
    push(1'b1, 16'hFFFF, 16'hFFFF, "R2 -1 x -1");
    drain();
  endtask

  task automatic t_sign_cross();    // R2
    push(1'b1, 16'h0001, 16'hFFFF, "R2 1 x -1");
    push(1'b1, 16'hFFFF, 16'h0001, "R2 -1 x 1");
    push(1'b1, 16'h7FFF, 16'h8001, "R2 max x -max");
    push(1'b1, 16'h0001, 16'h8000, "R2 1 x min");
    push(1'b1, 16'hFFFE, 16'h0002, "R2 -2 x 2");
    push(1'b1, 16'h8001, 16'h8001, "R2 -max x -max");
    drain();
  endtask

  task automatic t_walking();       // R1, R2 single-row shifts
    for (int i = 0; i < 16; i++) begin
      push(1'b0, 16'(1 << i), 16'hA5C3, "R1 walking a");
      push(1'b0, 16'h5A3C, 16'(1 << i), "R1 walking b");
      push(1'b1, 16'h9237, 16'(1 << i), "R2 walking b");
    end
    drain();
  endtask

  task automatic t_mode_switch();   // R10 back to back, R6 throughput
    for (int i = 0; i < 6; i++) begin
      push(1'b1, 16'hFFFF, 16'hFFFF, "R10 signed slot");
      push(1'b0, 16'hFFFF, 16'hFFFF, "R10 unsigned slot");
      push(1'b1, 16'h8000, 16'hC000, "R10 signed neg");
      push(1'b0, 16'h8000, 16'hC000, "R10 unsigned high");
    end
    drain();
  endtask

  task automatic t_hold();          // R7
    push(1'b0, 16'h1234, 16'h5678, "R7 held product");
    drain();
    for (int i = 0; i < 6; i++) begin
      idle(1);
      chk(out_p === last_p, "R7 hold while idle", out_p, last_p);
    end
  endtask

  task automatic t_reset_flight();  // R9
    push(1'b0, 16'h00FF, 16'h00FF, "R9 in flight");
    push(1'b1, 16'h8000, 16'h0003, "R9 in flight");
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    q.delete();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_valid === 1'b0, "R9 flight dropped", {31'b0, out_valid}, 32'd0);
    end
    rst = 1'b0;
    idle(5);   // monitor checks no stale result appears
    push(1'b1, 16'h0003, 16'hFFFD, "R9 first after reset");
    drain();
  endtask

  task automatic t_random_gaps();   // R1, R2, R6, R7; internals R3, R4, R5
    for (int i = 0; i < 1500; i++) begin
      push(1'($urandom), 16'($urandom), 16'($urandom), "R1/R2 random");
      if (($urandom % 4) == 0) idle(1 + int'($urandom % 3));
    end
    drain();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    t_reset_state();
    t_corners();
    t_sign_cross();
    t_walking();
    t_mode_switch();
    t_hold();
    t_reset_flight();
    t_random_gaps();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule